// File: doc/BRIEF.md
# Floppy Controller Rate Select Register

This block is the write-only rate select register of a floppy disk controller, together with the side effects a write to it causes. The host writes one byte. The block splits that byte into four things: a 2-bit data rate code, a 3-bit write precompensation code, a manual low-power flag and a software reset request. The reset request becomes a single-cycle pulse, and the register bit behind it clears itself.

A second host register, the configuration control register, can also write the data rate. The active rate therefore follows whichever of the two registers was written last. Manual low-power mode gates off the controller clock enable and the data separator enable. It ends on a software reset, or when the host touches the data register or the main status register. Software can read the last written byte, with the reset bit cleared, through a separate read-only shadow port.

All outputs come from registers and change on the clock edge that samples the request.

Top module: `fdc_rate_ctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block loads 0x02 into its register. After that edge: `active_rate`=2'b10 (250 Kbps), `precomp_code`=3'b000, `low_power`=0, `soft_rst_pulse`=0, `shadow_q`=8'h02, and both enables are 1.
- R2: A write (`rsel_wr_en`=1) loads bits 1:0 of `rsel_wr_data` into `active_rate` at that clock edge.
- R3: A configuration control write (`ccr_wr_en`=1) loads `ccr_wr_data` into `active_rate` when there is no rate select write in the same cycle. If both registers are written in the same cycle, the rate select write wins. Otherwise the most recent write sets the rate.
- R4: A write loads bits 4:2 of `rsel_wr_data` into `precomp_code`. Code 000 means the default delay. Configuration control writes and register accesses leave `precomp_code` unchanged.
- R5: A write with bit 7=0 sets `low_power` to bit 6 of the written byte. A write with bit 7=1 clears `low_power`.
- R6: An access strobe (`data_reg_acc` or `msr_acc`) without a same-cycle write clears `low_power` at that edge. A configuration control write does not change `low_power`.
- R7: `core_clk_en` and `sep_en` are 0 exactly while `low_power` is 1.
- R8: A write with bit 7=1 drives `soft_rst_pulse` high for exactly the one cycle after that edge. The pulse stays low at all other times.
- R9: `shadow_q` holds the last written byte with bit 7 forced to 0. Configuration control writes leave it unchanged.
- R10: A software reset leaves the rate, precompensation and shadow contents exactly as the write that requested it loaded them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| rsel_wr_en | input | 1 | Host write strobe for the rate select register |
| rsel_wr_data | input | 8 | Byte written to the rate select register |
| ccr_wr_en | input | 1 | Host write strobe for the configuration control register |
| ccr_wr_data | input | 2 | Data rate field of the configuration control write |
| data_reg_acc | input | 1 | Host access to the data register |
| msr_acc | input | 1 | Host access to the main status register |
| active_rate | output | 2 | Data rate code currently in force |
| precomp_code | output | 3 | Write precompensation select |
| low_power | output | 1 | Manual low-power mode flag |
| core_clk_en | output | 1 | Controller clock enable, low in low-power mode |
| sep_en | output | 1 | Data separator enable, low in low-power mode |
| soft_rst_pulse | output | 1 | One-cycle software reset pulse |
| shadow_q | output | 8 | Read-only copy of the last written byte, bit 7 zero |

## Verification
The bench builds the block with its default widths: an 8-bit byte, a 2-bit rate and a 3-bit precompensation field. With these widths, random bytes reach all four rate codes and all eight precompensation codes. The random traffic also produces same-cycle collisions between the two rate writers, and between a low-power write and an access strobe. Directed sequences cover the cases random traffic rarely lines up:
- back-to-back software resets;
- leaving low-power mode through either access strobe;
- checking that the contents survive a reset request.

// File: rtl/fdc_rate_pkg.sv
// Package: shared widths, reset value and rate encoding for the rate select
// register. Assumes the register byte is exactly rate + precomp + 3 bits wide.
package fdc_rate_pkg;
    localparam int unsigned RATE_W  = 2;
    localparam int unsigned PCOMP_W = 3;
    localparam int unsigned BYTE_W  = RATE_W + PCOMP_W + 3;
    localparam logic [BYTE_W-1:0] HW_RESET_VAL = 8'h02;

    typedef enum logic [RATE_W-1:0] {
        RATE_C0  = 2'b00,
        RATE_C1  = 2'b01,
        RATE_250 = 2'b10,
        RATE_C3  = 2'b11
    } rate_code_e;
endpackage

// File: rtl/rsel_field_reg.sv
// Module: holds the precompensation field and the shadow copy of the last
// written byte. Assumes the caller presents a single write strobe per cycle.
module rsel_field_reg #(
    parameter int unsigned BYTE_W  = 8,
    parameter int unsigned RATE_W  = 2,
    parameter int unsigned PCOMP_W = 3,
    parameter logic [BYTE_W-1:0] RST_VAL = 8'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [PCOMP_W-1:0] pcomp,
    output logic [BYTE_W-1:0] shadow
);
    localparam int unsigned PC_LSB = RATE_W;
    localparam int unsigned PC_MSB = RATE_W + PCOMP_W - 1;
    localparam int unsigned SR_BIT = BYTE_W - 1;

    logic [BYTE_W-1:0] shadow_nxt;

    // Build the shadow value: the written byte with the self-clearing bit zeroed.
    always_comb begin
        shadow_nxt         = wr_data;
        shadow_nxt[SR_BIT] = 1'b0;
    end

    // Load the precompensation field on a write; the hardware reset restores the default.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pcomp <= RST_VAL[PC_MSB:PC_LSB];
        else if (wr_en)
            pcomp <= wr_data[PC_MSB:PC_LSB];
    end

    // Keep the readable copy of the last written byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow <= RST_VAL;
        else if (wr_en)
            shadow <= shadow_nxt;
    end
endmodule

// File: rtl/rate_owner.sv
// Module: settles the active data rate between two writers. The most recent
// writer wins; when both write in the same cycle the rate select port wins.
module rate_owner #(
    parameter int unsigned RATE_W = 2,
    parameter logic [RATE_W-1:0] RST_RATE = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_wr,
    input  logic [RATE_W-1:0] a_rate,
    input  logic              b_wr,
    input  logic [RATE_W-1:0] b_rate,
    output logic [RATE_W-1:0] rate
);
    // Track the rate from whichever port wrote last, port a first on a tie.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rate <= RST_RATE;
        else if (a_wr)
            rate <= a_rate;
        else if (b_wr)
            rate <= b_rate;
    end
endmodule

// File: rtl/lowpwr_ctrl.sv
// Module: manual low-power flag and the clock and separator enables it gates.
// Assumes the write path decides the flag when a write and an access coincide.
module lowpwr_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_lp,
    input  logic wr_swr,
    input  logic acc,
    output logic lp,
    output logic clk_en,
    output logic sep_en
);
    logic lp_nxt;

    // Next state of the flag: writes set or clear it, and an access ends it.
    always_comb begin
        lp_nxt = lp;
        if (wr_en)
            lp_nxt = wr_lp & ~wr_swr;
        else if (acc)
            lp_nxt = 1'b0;
    end

    // Hold the flag and the registered enables so that they change together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lp     <= 1'b0;
            clk_en <= 1'b1;
            sep_en <= 1'b1;
        end else begin
            lp     <= lp_nxt;
            clk_en <= ~lp_nxt;
            sep_en <= ~lp_nxt;
        end
    end
endmodule

// File: rtl/swrst_gen.sv
// Module: turns a write with the reset bit set into a one-cycle pulse. The
// register bit itself is never stored, so it reads back as zero.
module swrst_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_swr,
    output logic pulse
);
    // Issue one pulse cycle per qualifying write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse <= 1'b0;
        else
            pulse <= wr_en & wr_swr;
    end
endmodule

// File: rtl/fdc_rate_ctl.sv
// Module: top of the rate select register. Splits a host byte into rate,
// precompensation, low-power and reset-request fields. Assumes the byte layout
// is reset request (MSB), low power, reserved, precomp, rate (LSBs).
module fdc_rate_ctl
    import fdc_rate_pkg::*;
#(
    parameter int unsigned R_W = RATE_W,
    parameter int unsigned P_W = PCOMP_W,
    parameter int unsigned B_W = BYTE_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rsel_wr_en,
    input  logic [B_W-1:0] rsel_wr_data,
    input  logic           ccr_wr_en,
    input  logic [R_W-1:0] ccr_wr_data,
    input  logic           data_reg_acc,
    input  logic           msr_acc,
    output logic [R_W-1:0] active_rate,
    output logic [P_W-1:0] precomp_code,
    output logic           low_power,
    output logic           core_clk_en,
    output logic           sep_en,
    output logic           soft_rst_pulse,
    output logic [B_W-1:0] shadow_q
);
    localparam int unsigned SR_BIT = B_W - 1;
    localparam int unsigned LP_BIT = B_W - 2;
    localparam logic [B_W-1:0] RST_V = HW_RESET_VAL;

    logic host_acc;
    logic wr_swr;
    logic wr_lp;

    // Decode the single-bit controls of the written byte and merge the access strobes.
    always_comb begin
        wr_swr   = rsel_wr_data[SR_BIT];
        wr_lp    = rsel_wr_data[LP_BIT];
        host_acc = data_reg_acc | msr_acc;
    end

    rsel_field_reg #(
        .BYTE_W (B_W),
        .RATE_W (R_W),
        .PCOMP_W(P_W),
        .RST_VAL(RST_V)
    ) u_fields (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (rsel_wr_en),
        .wr_data(rsel_wr_data),
        .pcomp  (precomp_code),
        .shadow (shadow_q)
    );

    rate_owner #(
        .RATE_W  (R_W),
        .RST_RATE(RST_V[R_W-1:0])
    ) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .a_wr  (rsel_wr_en),
        .a_rate(rsel_wr_data[R_W-1:0]),
        .b_wr  (ccr_wr_en),
        .b_rate(ccr_wr_data),
        .rate  (active_rate)
    );

    lowpwr_ctrl u_lp (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (rsel_wr_en),
        .wr_lp (wr_lp),
        .wr_swr(wr_swr),
        .acc   (host_acc),
        .lp    (low_power),
        .clk_en(core_clk_en),
        .sep_en(sep_en)
    );

    swrst_gen u_swr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (rsel_wr_en),
        .wr_swr(wr_swr),
        .pulse (soft_rst_pulse)
    );
endmodule

// File: rtl/fdc_rate_ctl_chk.sv
// Module: assertion checker bound to the top; observes ports only.
module fdc_rate_ctl_chk #(
    parameter int unsigned R_W = 2,
    parameter int unsigned P_W = 3,
    parameter int unsigned B_W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           rsel_wr_en,
    input logic [B_W-1:0] rsel_wr_data,
    input logic           ccr_wr_en,
    input logic [R_W-1:0] ccr_wr_data,
    input logic           data_reg_acc,
    input logic           msr_acc,
    input logic [R_W-1:0] active_rate,
    input logic [P_W-1:0] precomp_code,
    input logic           low_power,
    input logic           core_clk_en,
    input logic           sep_en,
    input logic           soft_rst_pulse,
    input logic [B_W-1:0] shadow_q
);
    a_r2_rate_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        rsel_wr_en |=> active_rate == $past(rsel_wr_data[R_W-1:0]));

    a_r3_rate_from_ccr: assert property (@(posedge clk) disable iff (!rst_n)
        (ccr_wr_en && !rsel_wr_en) |=> active_rate == $past(ccr_wr_data));

    a_r4_precomp_held: assert property (@(posedge clk) disable iff (!rst_n)
        !rsel_wr_en |=> $stable(precomp_code));

    a_r6_access_exits: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_reg_acc || msr_acc) && !rsel_wr_en) |=> !low_power);

    a_r7_gating: assert property (@(posedge clk) disable iff (!rst_n)
        low_power |-> (!core_clk_en && !sep_en));

    a_r8_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsel_wr_en && rsel_wr_data[B_W-1]) |=> !soft_rst_pulse);

    a_r9_shadow_b7_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !shadow_q[B_W-1]);
endmodule

bind fdc_rate_ctl fdc_rate_ctl_chk #(
    .R_W(R_W), .P_W(P_W), .B_W(B_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rsel_wr_en(rsel_wr_en), .rsel_wr_data(rsel_wr_data),
    .ccr_wr_en(ccr_wr_en), .ccr_wr_data(ccr_wr_data), .data_reg_acc(data_reg_acc),
    .msr_acc(msr_acc), .active_rate(active_rate), .precomp_code(precomp_code),
    .low_power(low_power), .core_clk_en(core_clk_en), .sep_en(sep_en),
    .soft_rst_pulse(soft_rst_pulse), .shadow_q(shadow_q)
);

// File: tb/sim_fdc_rate_ctl.sv
// Bench: behavioural reference model updated at each rising edge, compared
// against every output at each falling edge; inputs change on falling edges.
module sim_fdc_rate_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rsel_wr_en;
    logic [7:0] rsel_wr_data;
    logic       ccr_wr_en;
    logic [1:0] ccr_wr_data;
    logic       data_reg_acc;
    logic       msr_acc;
    logic [1:0] active_rate;
    logic [2:0] precomp_code;
    logic       low_power;
    logic       core_clk_en;
    logic       sep_en;
    logic       soft_rst_pulse;
    logic [7:0] shadow_q;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference model state
    int m_rate, m_pc, m_lp, m_pulse, m_shadow;

    always #(CLK_PERIOD/2) clk = ~clk;

    fdc_rate_ctl u0 (
        .clk(clk), .rst_n(rst_n), .rsel_wr_en(rsel_wr_en), .rsel_wr_data(rsel_wr_data),
        .ccr_wr_en(ccr_wr_en), .ccr_wr_data(ccr_wr_data), .data_reg_acc(data_reg_acc),
        .msr_acc(msr_acc), .active_rate(active_rate), .precomp_code(precomp_code),
        .low_power(low_power), .core_clk_en(core_clk_en), .sep_en(sep_en),
        .soft_rst_pulse(soft_rst_pulse), .shadow_q(shadow_q)
    );

    // Reference model: the requirements written as plain integer updates.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_rate = 2; m_pc = 0; m_lp = 0; m_pulse = 0; m_shadow = 8'h02;
        end else begin
            m_pulse = (rsel_wr_en && rsel_wr_data[7]) ? 1 : 0;
            if (rsel_wr_en) begin
                m_rate   = rsel_wr_data % 4;
                m_pc     = (rsel_wr_data / 4) % 8;
                m_shadow = rsel_wr_data % 128;
                m_lp     = rsel_wr_data[7] ? 0 : int'(rsel_wr_data[6]);
            end else begin
                if (ccr_wr_en) m_rate = ccr_wr_data;
                if (data_reg_acc || msr_acc) m_lp = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output with the model away from the active edge.
    task automatic compare_all();
        chk(int'(active_rate) == m_rate, "R2/R3 active_rate", active_rate, m_rate);
        chk(int'(precomp_code) == m_pc, "R4 precomp_code", precomp_code, m_pc);
        chk(int'(low_power) == m_lp, "R5/R6 low_power", low_power, m_lp);
        chk(int'(core_clk_en) == 1 - m_lp && int'(sep_en) == 1 - m_lp,
            "R7 enables", {core_clk_en, sep_en}, (1 - m_lp) * 3);
        chk(int'(soft_rst_pulse) == m_pulse, "R8 soft_rst_pulse", soft_rst_pulse, m_pulse);
        chk(int'(shadow_q) == m_shadow, "R9 shadow_q", shadow_q, m_shadow);
    endtask

    always @(negedge clk) if (rst_n === 1'b1 && !done) compare_all();

    task automatic idle();
        rsel_wr_en = 0; rsel_wr_data = 0; ccr_wr_en = 0; ccr_wr_data = 0;
        data_reg_acc = 0; msr_acc = 0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        idle(); rsel_wr_en = 1; rsel_wr_data = d; step(); idle();
    endtask

    task automatic ccr(input logic [1:0] d);
        idle(); ccr_wr_en = 1; ccr_wr_data = d; step(); idle();
    endtask

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        // R1: reset values after a reset edge
        chk(active_rate == 2'b10, "R1 rate", active_rate, 2);
        chk(precomp_code == 3'b000, "R1 precomp", precomp_code, 0);
        chk(low_power == 1'b0 && core_clk_en && sep_en, "R1 power", low_power, 0);
        chk(soft_rst_pulse == 1'b0, "R1 pulse", soft_rst_pulse, 0);
        chk(shadow_q == 8'h02, "R1 shadow", shadow_q, 2);
        rst_n = 1;

        // R2, R4: plain write
        wr(8'h1D);
        chk(active_rate == 2'b01 && precomp_code == 3'b111, "R2 R4 directed", {precomp_code, active_rate}, 5'h1D);
        // R3: ccr write after rsel, then rsel after ccr, then tie
        ccr(2'b11);
        chk(active_rate == 2'b11 && precomp_code == 3'b111, "R3 ccr later wins", active_rate, 3);
        wr(8'h00);
        chk(active_rate == 2'b00, "R3 rsel later wins", active_rate, 0);
        idle(); rsel_wr_en = 1; rsel_wr_data = 8'h01; ccr_wr_en = 1; ccr_wr_data = 2'b10; step(); idle();
        chk(active_rate == 2'b01, "R3 tie rsel wins", active_rate, 1);
        // R5, R6, R7: low-power entry and exits
        wr(8'h40);
        chk(low_power && !core_clk_en && !sep_en, "R5 R7 enter", low_power, 1);
        ccr(2'b00);
        chk(low_power == 1'b1 && shadow_q == 8'h40, "R6 R9 ccr no effect", {low_power, shadow_q}, 9'h140);
        idle(); msr_acc = 1; step(); idle();
        chk(!low_power && core_clk_en, "R6 msr exit", low_power, 0);
        wr(8'h40);
        idle(); data_reg_acc = 1; step(); idle();
        chk(!low_power, "R6 data exit", low_power, 0);
        wr(8'h40);
        idle(); rsel_wr_en = 1; rsel_wr_data = 8'h48; msr_acc = 1; step(); idle();
        chk(low_power == 1'b1, "R6 write beats access", low_power, 1);
        // R8, R10: software reset
        idle(); rsel_wr_en = 1; rsel_wr_data = 8'hCE; step(); idle();
        chk(soft_rst_pulse && !low_power, "R8 pulse and exit", soft_rst_pulse, 1);
        step();
        chk(!soft_rst_pulse, "R8 single cycle", soft_rst_pulse, 0);
        chk(shadow_q == 8'h4E && active_rate == 2'b10 && precomp_code == 3'b011,
            "R10 contents kept", shadow_q, 8'h4E);
        wr(8'h80); wr(8'h80);
        chk(soft_rst_pulse, "R8 back to back", soft_rst_pulse, 1);
        step();

        // Random phase, compared every cycle by the monitor.
        for (int i = 0; i < 3000; i++) begin
            idle();
            rsel_wr_en   = ($urandom % 4) == 0;
            rsel_wr_data = 8'($urandom);
            ccr_wr_en    = ($urandom % 3) == 0;
            ccr_wr_data  = 2'($urandom);
            data_reg_acc = ($urandom % 6) == 0;
            msr_acc      = ($urandom % 6) == 0;
            step();
        end
        idle();
        step();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule